// File: doc/BRIEF.md
# Two-Master Locking Bus Arbiter

This block sits between two bus masters and one slave. When the bus is free it picks an owner with fixed priority. Master 0 wins over master 1. It posts a registered request strobe to the slave and keeps that strobe up until the slave accepts. The slave's accept pulse is steered back to whichever master owns the bus. A transfer that the slave accepts without finishing in the same cycle marks the bus busy until the slave signals done. While the bus is busy, ownership cannot move.

Master 0 may hold the bus across several transfers. To do this it keeps its hold input high when the slave accepts one of its transfers. While the bus is held, master 1's requests are ignored and ownership stays frozen. The hold ends in the cycle after master 0 drops its hold input.

The logic has three small state machines. The phase machine has four states: `PH_FREE` (neither busy nor held), `PH_XFER` (busy, not held), `PH_HELD` (held, not busy) and `PH_HELD_XFER` (both). Its transitions are named as follows:
- *start*: accept without done, moving free to busy.
- *finish*: done, moving busy to not busy.
- *grab*: hold with master 0 owning and an accept, moving unheld to held.
- *release*: hold input low, moving held to unheld.

The request-post machine has two states, `REQ_IDLE` and `REQ_POSTED`. Its transitions are *post* (an eligible request) and *retire* (slave accept). The owner register takes `OWN_M0` or `OWN_M1` through its *arbitrate* transition, which fires only when the phase is `PH_FREE`.

Top module: `duo_lock_arbiter`

## Requirements
- R1: While reset is high and on the first cycle after it, slv_valid, bus_busy, bus_held, owner_id, m0_ack and m1_ack are all low. Reset is synchronous and active high.
- R2: When the bus is neither busy nor held, the owner_id of the next cycle is 0 if m0_req is high, otherwise 1 if m1_req is high, and is otherwise unchanged. owner_id 0 means master 0 and 1 means master 1.
- R3: While bus_busy or bus_held is high, owner_id keeps its value in the next cycle.
- R4: When slv_valid is low, slv_valid is high in the next cycle if and only if either of these holds: m0_req is high and bus_busy is low; or m1_req is high and both bus_busy and bus_held are low.
- R5: Once high, slv_valid stays high while slv_ack is low, and it is low in the cycle after slv_ack is seen high.
- R6: When bus_held is high, slv_valid is low and m0_req is low, slv_valid is low in the next cycle, whatever m1_req does.
- R7: m0_ack equals slv_ack when owner_id is 0 and is low otherwise. m1_ack equals slv_ack when owner_id is 1 and is low otherwise. Both follow slv_ack in the same cycle, and they are never high together.
- R8: When bus_busy is low, the bus_busy of the next cycle is high if and only if slv_ack is high and slv_done is low. When bus_busy is high, it stays high until slv_done is high and is low in the following cycle.
- R9: When bus_held is low, the bus_held of the next cycle is high if and only if m0_hold and slv_ack are high and owner_id is 0.
- R10: When bus_held is high, the bus_held of the next cycle equals m0_hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| m0_req | input | 1 | Master 0 bus request |
| m1_req | input | 1 | Master 1 bus request |
| m0_hold | input | 1 | Master 0 asks to keep the bus across transfers |
| m0_ack | output | 1 | Slave accept steered to master 0 |
| m1_ack | output | 1 | Slave accept steered to master 1 |
| slv_valid | output | 1 | Registered request posted to the slave |
| slv_ack | input | 1 | Slave accepts the posted request |
| slv_done | input | 1 | Slave finishes the current transfer |
| bus_busy | output | 1 | Registered: a transfer is in progress |
| bus_held | output | 1 | Registered: master 0 holds the bus |
| owner_id | output | 1 | Registered owner, 0 = master 0, 1 = master 1 |

## Verification
The block has no parameters, so the bench builds the single default configuration, and every state pair of the phase machine is reachable in it. Directed sequences cover the following cases:
- master 1 winning alone;
- both masters requesting at once;
- requests arriving while the bus is busy;
- accept and done in the same cycle;
- a hold that starts and then ends;
- master 1 knocking while the bus is held.

A long pseudo-random run then mixes the five inputs so that the reference model's next-state rules are compared in all sixteen combinations of busy, held, posted and owner.

// File: rtl/arb_pkg.sv
package arb_pkg;

    // Phase encoding: bit 0 = transfer in progress, bit 1 = bus held by master 0
    typedef enum logic [1:0] {
        PH_FREE      = 2'b00,
        PH_XFER      = 2'b01,
        PH_HELD      = 2'b10,
        PH_HELD_XFER = 2'b11
    } bus_phase_e;

    typedef enum logic {
        REQ_IDLE   = 1'b0,
        REQ_POSTED = 1'b1
    } post_e;

    typedef enum logic {
        OWN_M0 = 1'b0,
        OWN_M1 = 1'b1
    } owner_e;

    function automatic bus_phase_e phase_of(input logic held, input logic xfer);
        bus_phase_e p;
        unique case ({held, xfer})
            2'b00:   p = PH_FREE;
            2'b01:   p = PH_XFER;
            2'b10:   p = PH_HELD;
            default: p = PH_HELD_XFER;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/arb_phase_fsm.sv
module arb_phase_fsm
    import arb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   slv_ack,
    input  logic   slv_done,
    input  logic   m0_hold,
    input  owner_e owner,
    output logic   busy,
    output logic   held
);

    bus_phase_e state_q, state_d;
    logic       start_c;
    logic       grab_c;
    logic       xfer_n;
    logic       held_n;

    // start: accepted but not finished in the same cycle
    // grab: master 0 owns, keeps its hold input high, and the slave accepts
    assign start_c = slv_ack & ~slv_done;
    assign grab_c  = m0_hold & slv_ack & (owner == OWN_M0);

    always_comb begin
        xfer_n = 1'b0;
        held_n = 1'b0;
        unique case (state_q)
            PH_FREE: begin
                xfer_n = start_c;
                held_n = grab_c;
            end
            PH_XFER: begin
                xfer_n = ~slv_done;
                held_n = grab_c;
            end
            PH_HELD: begin
                xfer_n = start_c;
                held_n = m0_hold;
            end
            PH_HELD_XFER: begin
                xfer_n = ~slv_done;
                held_n = m0_hold;
            end
            default: begin
                xfer_n = 1'b0;
                held_n = 1'b0;
            end
        endcase
        state_d = phase_of(held_n, xfer_n);
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= PH_FREE;
        else     state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            PH_FREE:      begin busy = 1'b0; held = 1'b0; end
            PH_XFER:      begin busy = 1'b1; held = 1'b0; end
            PH_HELD:      begin busy = 1'b0; held = 1'b1; end
            PH_HELD_XFER: begin busy = 1'b1; held = 1'b1; end
            default:      begin busy = 1'b0; held = 1'b0; end
        endcase
    end

    assert_busy_set_R8: assert property (@(posedge clk) disable iff (rst)
        (!busy && slv_ack && !slv_done) |=> busy);

    assert_busy_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && slv_done) |=> !busy);

    assert_busy_stay_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && !slv_done) |=> busy);

    assert_hold_follow_R10: assert property (@(posedge clk) disable iff (rst)
        held |=> (held == $past(m0_hold)));

    assert_hold_grab_R9: assert property (@(posedge clk) disable iff (rst)
        (!held && !(m0_hold && slv_ack && owner == OWN_M0)) |=> !held);

endmodule

// File: rtl/arb_owner_reg.sv
module arb_owner_reg
    import arb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   m0_req,
    input  logic   m1_req,
    input  logic   busy,
    input  logic   held,
    output owner_e owner
);

    owner_e owner_q, owner_d;

    // arbitrate only when the bus is free; master 0 first
    always_comb begin
        owner_d = owner_q;
        unique case ({busy | held, m0_req, m1_req})
            3'b010, 3'b011: owner_d = OWN_M0;
            3'b001:         owner_d = OWN_M1;
            default:        owner_d = owner_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) owner_q <= OWN_M0;
        else     owner_q <= owner_d;
    end

    assign owner = owner_q;

    assert_owner_frozen_R3: assert property (@(posedge clk) disable iff (rst)
        (busy || held) |=> $stable(owner));

    assert_owner_prio_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy && !held && m0_req) |=> (owner == OWN_M0));

    assert_owner_m1_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy && !held && !m0_req && m1_req) |=> (owner == OWN_M1));

endmodule

// File: rtl/arb_post_fsm.sv
module arb_post_fsm
    import arb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic m0_req,
    input  logic m1_req,
    input  logic busy,
    input  logic held,
    input  logic slv_ack,
    output logic valid
);

    post_e state_q, state_d;
    logic  post_c;

    // post: master 0 needs only a non-busy bus; master 1 also needs it unheld
    assign post_c = (m0_req & ~busy) | (m1_req & ~busy & ~held);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REQ_IDLE:   state_d = post_c  ? REQ_POSTED : REQ_IDLE;
            REQ_POSTED: state_d = slv_ack ? REQ_IDLE   : REQ_POSTED;
            default:    state_d = REQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= REQ_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            REQ_POSTED: valid = 1'b1;
            default:    valid = 1'b0;
        endcase
    end

    assert_valid_keep_R5: assert property (@(posedge clk) disable iff (rst)
        (valid && !slv_ack) |=> valid);

    assert_valid_drop_R5: assert property (@(posedge clk) disable iff (rst)
        (valid && slv_ack) |=> !valid);

    assert_valid_rise_R4: assert property (@(posedge clk) disable iff (rst)
        (!valid && !busy && m0_req) |=> valid);

    assert_no_m1_when_held_R6: assert property (@(posedge clk) disable iff (rst)
        (!valid && held && !m0_req) |=> !valid);

endmodule

// File: rtl/duo_lock_arbiter.sv
module duo_lock_arbiter
    import arb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic m0_req,
    input  logic m1_req,
    input  logic m0_hold,
    output logic m0_ack,
    output logic m1_ack,
    output logic slv_valid,
    input  logic slv_ack,
    input  logic slv_done,
    output logic bus_busy,
    output logic bus_held,
    output logic owner_id
);

    owner_e owner;
    logic   busy;
    logic   held;

    arb_phase_fsm u_phase (
        .clk      (clk),
        .rst      (rst),
        .slv_ack  (slv_ack),
        .slv_done (slv_done),
        .m0_hold  (m0_hold),
        .owner    (owner),
        .busy     (busy),
        .held     (held)
    );

    arb_owner_reg u_owner (
        .clk    (clk),
        .rst    (rst),
        .m0_req (m0_req),
        .m1_req (m1_req),
        .busy   (busy),
        .held   (held),
        .owner  (owner)
    );

    arb_post_fsm u_post (
        .clk     (clk),
        .rst     (rst),
        .m0_req  (m0_req),
        .m1_req  (m1_req),
        .busy    (busy),
        .held    (held),
        .slv_ack (slv_ack),
        .valid   (slv_valid)
    );

    // steer the slave accept to the registered owner
    always_comb begin
        m0_ack = 1'b0;
        m1_ack = 1'b0;
        unique case (owner)
            OWN_M0:  m0_ack = slv_ack;
            OWN_M1:  m1_ack = slv_ack;
            default: begin m0_ack = 1'b0; m1_ack = 1'b0; end
        endcase
    end

    assign bus_busy = busy;
    assign bus_held = held;
    assign owner_id = owner;

    assert_ack_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        !(m0_ack && m1_ack));

    assert_ack_follows_R7: assert property (@(posedge clk) disable iff (rst)
        (m0_ack || m1_ack) == slv_ack);

endmodule

// File: tb/sim_duo_lock_arbiter.sv
`timescale 1ns/1ps
module sim_duo_lock_arbiter;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m0_req = 1'b0, m1_req = 1'b0, m0_hold = 1'b0;
    logic slv_ack = 1'b0, slv_done = 1'b0;
    logic m0_ack, m1_ack, slv_valid, bus_busy, bus_held, owner_id;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic valid;
        logic busy;
        logic held;
        logic owner;
    } exp_t;

    exp_t sb_q[$];

    // reference model state
    logic r_valid = 1'b0, r_busy = 1'b0, r_held = 1'b0, r_owner = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    duo_lock_arbiter u0 (
        .clk(clk), .rst(rst),
        .m0_req(m0_req), .m1_req(m1_req), .m0_hold(m0_hold),
        .m0_ack(m0_ack), .m1_ack(m1_ack),
        .slv_valid(slv_valid), .slv_ack(slv_ack), .slv_done(slv_done),
        .bus_busy(bus_busy), .bus_held(bus_held), .owner_id(owner_id)
    );

    task automatic chk(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", what, act, exp, $time);
        end
    endtask

    // driver: apply one cycle of inputs at a falling edge, push expectation
    task automatic step(input logic r0, input logic r1, input logic hl,
                        input logic ak, input logic dn);
        exp_t e;
        m0_req = r0; m1_req = r1; m0_hold = hl; slv_ack = ak; slv_done = dn;
        #1;
        chk(m0_ack, ak & (r_owner == 1'b0), "R7 m0_ack");
        chk(m1_ack, ak & (r_owner == 1'b1), "R7 m1_ack");
        // next-state rules
        e.valid = r_valid ? ~ak : ((r0 & ~r_busy) | (r1 & ~r_busy & ~r_held));
        e.busy  = r_busy ? ~dn : (ak & ~dn);
        e.held  = r_held ? hl : (hl & ak & (r_owner == 1'b0));
        e.owner = (r_busy | r_held) ? r_owner : (r0 ? 1'b0 : (r1 ? 1'b1 : r_owner));
        sb_q.push_back(e);
        r_valid = e.valid; r_busy = e.busy; r_held = e.held; r_owner = e.owner;
        @(negedge clk);
    endtask

    // monitor: compare registered outputs just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                chk(slv_valid, e.valid, "R4 R5 R6 slv_valid");
                chk(bus_busy,  e.busy,  "R8 bus_busy");
                chk(bus_held,  e.held,  "R9 R10 bus_held");
                chk(owner_id,  e.owner, "R2 R3 owner_id");
            end
        end
    end

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        checks++;
        $display("FAIL watchdog expired at %0t", $time);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: state under reset
        chk(slv_valid, 1'b0, "R1 slv_valid");
        chk(bus_busy,  1'b0, "R1 bus_busy");
        chk(bus_held,  1'b0, "R1 bus_held");
        chk(owner_id,  1'b0, "R1 owner_id");
        chk(m0_ack,    1'b0, "R1 m0_ack");
        chk(m1_ack,    1'b0, "R1 m1_ack");
        rst = 1'b0;

        // idle cycle
        step(0, 0, 0, 0, 0);
        // R2: master 1 alone wins; R4 post
        step(0, 1, 0, 0, 0);
        step(0, 1, 0, 0, 0);       // R5: held while no accept
        step(0, 0, 0, 1, 0);       // R7 m1_ack, R8 busy set
        step(1, 0, 0, 0, 0);       // R3 frozen, R4 no post while busy
        step(1, 0, 0, 0, 1);       // R8 finish
        // R2: both request, master 0 wins
        step(1, 1, 0, 0, 0);
        step(0, 0, 0, 1, 1);       // accept+done same cycle: no busy
        // R9: grab the bus
        step(1, 0, 1, 0, 0);
        step(0, 0, 1, 1, 0);       // accept with hold, owner 0
        // R6: master 1 knocks while held
        step(0, 1, 1, 0, 1);
        step(0, 1, 1, 0, 0);
        step(0, 1, 1, 0, 0);
        step(0, 1, 0, 0, 0);       // R10 release
        step(0, 1, 0, 0, 0);       // R2 master 1 now wins
        step(0, 0, 0, 1, 1);

        // pseudo-random mix
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 2) == 0, ($urandom % 2) == 0, ($urandom % 10) < 7,
                 ($urandom % 10) < 3, ($urandom % 10) < 3);
        end

        @(posedge clk);
        #2;
        finish_run();
    end

endmodule